// File: doc/BRIEF.md
# Multi-Task Liveness Aggregator

This block stands between a set of software tasks and a hardware watchdog. It lets the watchdog be kicked only when every monitored task has shown signs of life since the last evaluation. Without it, one healthy loop could keep the system alive while the other tasks are stuck. Up to `N_TASKS` task slots each have a check-in strobe and an entry-increment strobe. An enable mask marks which slots are in use.

A periodic `check_tick` closes each interval. In flag mode, a slot passes when its check-in strobe fired at least once during the interval. In counter mode, a slot passes when the number of cycles its increment strobe was high lies inside that slot's lower and upper guard band, both bounds inclusive. If every enabled slot passes, the block sends a one-cycle kick toward the watchdog. If any enabled slot fails, no kick is sent and the watchdog times out on its own. The per-slot records are cleared at every tick, pass or fail. A status vector names the slots that failed the latest evaluation.

The controller is a three-state machine:
- `ST_GATHER` collects evidence.
- `ST_KICK` drives the kick.
- `ST_WITHHOLD` marks a failed evaluation.

A tick moves the machine from any state to `ST_KICK` when all enabled slots pass (transition *pass*) and to `ST_WITHHOLD` when any enabled slot fails (transition *fail*). A cycle without a tick returns it to `ST_GATHER` (transition *idle*).

Top module: `liveness_aggregator`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `kick` is 0 and `fail_vec` is all zero.
- R2: In flag mode (`cnt_mode`=0), `kick` is high for exactly the one cycle that follows a `check_tick` edge, provided every enabled slot strobed `checkin` in at least one cycle since the previous tick.
- R3: If an enabled slot has no check-in in the interval, `kick` stays 0 after the tick, and bit i of `fail_vec` (bit i belongs to slot i) is 1 for each such slot.
- R4: Every tick clears all check-in flags and entry counts, whether the evaluation passed or failed, so a tick that follows an empty interval fails every enabled slot.
- R5: A `checkin` or `entry_inc` strobe in the same cycle as `check_tick` is not used in that evaluation; it counts as the first event of the next interval.
- R6: A slot whose `task_en` bit is 0 never blocks a kick, and its `fail_vec` bit is 0 after each tick. When all slots are disabled, every tick produces a kick.
- R7: In counter mode (`cnt_mode`=1), slot i passes only if lo ≤ count ≤ hi. Here count is the number of cycles its `entry_inc` bit was high in the interval. lo and hi are slot i's bounds, held in bits [i*CNT_W +: CNT_W] of `band_lo` and `band_hi`.
- R8: An entry count saturates at 2^CNT_W−1 and never wraps.
- R9: `fail_vec` changes only in the cycle after a tick and holds its value between ticks.
- R10: `kick` is never high while `fail_vec` is non-zero, and it is 0 in every cycle that does not directly follow a tick.
- R11: In counter mode `checkin` strobes have no effect on the verdict. In flag mode `entry_inc` strobes and the bands have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 1 | 0 = flag mode, 1 = counter (guard band) mode |
| task_en | input | N_TASKS | Per-slot enable mask |
| checkin | input | N_TASKS | Per-slot check-in strobe |
| entry_inc | input | N_TASKS | Per-slot entry counter increment strobe |
| band_lo | input | N_TASKS*CNT_W | Per-slot lower bound on the entry count, inclusive |
| band_hi | input | N_TASKS*CNT_W | Per-slot upper bound on the entry count, inclusive |
| check_tick | input | 1 | Periodic evaluation strobe |
| kick | output | 1 | One-cycle kick pulse toward the watchdog |
| fail_vec | output | N_TASKS | Slots that failed the latest evaluation |

## Verification
Flag mode is tried with:
- all slots checking in together in one cycle;
- check-ins spread over several cycles;
- a single missing slot, which separates the all-set test from an any-set test.

An interval that is empty because every strobe landed on the tick itself separates clearing from carrying over, and shows that same-cycle strobes move into the next interval. Counter mode is driven with counts on, below and above the band edges, with check-in strobes present but irrelevant. A long burst against a band at the maximum count separates saturation from wrap-around. Masked patterns show that disabled slots neither block the kick nor report failure.

// File: rtl/liveagg_pkg.sv
package liveagg_pkg;

    typedef enum logic [1:0] {
        ST_GATHER   = 2'd0,
        ST_KICK     = 2'd1,
        ST_WITHHOLD = 2'd2
    } agg_state_t;

    function automatic logic in_band(input logic [31:0] val,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/liveagg_slot.sv
module liveagg_slot
    import liveagg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             checkin,
    input  logic             entry_inc,
    input  logic             check_tick,
    input  logic             cnt_mode,
    input  logic [CNT_W-1:0] band_lo,
    input  logic [CNT_W-1:0] band_hi,
    output logic             pass
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             seen_q;
    logic [CNT_W-1:0] count_q;

    // Evidence store: a tick reloads with this cycle's strobe (next interval)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            count_q <= '0;
        end else if (check_tick) begin
            seen_q  <= checkin;
            count_q <= entry_inc ? CNT_W'(1) : '0;
        end else begin
            if (checkin) begin
                seen_q <= 1'b1;
            end
            if (entry_inc && (count_q != CNT_MAX)) begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        if (cnt_mode) begin
            pass = in_band(32'(count_q), 32'(band_lo), 32'(band_hi));
        end else begin
            pass = seen_q;
        end
    end

    // R5: the flag after a tick reflects only the strobe of the tick cycle
    a_r5_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        check_tick |=> (seen_q == $past(checkin)));

    // R8: a full counter stays full until the next tick
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == CNT_MAX) && !check_tick) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/liveagg_fsm.sv
module liveagg_fsm
    import liveagg_pkg::*;
#(
    parameter int N_TASKS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check_tick,
    input  logic               all_pass,
    input  logic [N_TASKS-1:0] slot_fail,
    output logic               kick,
    output logic [N_TASKS-1:0] fail_vec
);

    agg_state_t state_q, state_d;

    always_comb begin
        state_d = ST_GATHER;
        unique case (state_q)
            ST_GATHER, ST_KICK, ST_WITHHOLD: begin
                if (check_tick) begin
                    state_d = all_pass ? ST_KICK : ST_WITHHOLD;
                end else begin
                    state_d = ST_GATHER;
                end
            end
            default: state_d = ST_GATHER;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: status latched at each tick, kick decoded from state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_vec <= '0;
        end else if (check_tick) begin
            fail_vec <= slot_fail;
        end
    end

    assign kick = (state_q == ST_KICK);

    // R2: a kick is always preceded by a tick
    a_r2_kick_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(check_tick));

    // R10: kick and reported failure are mutually exclusive
    a_r10_kick_clean: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> (fail_vec == '0));

    // R9: status holds between ticks
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !check_tick |=> $stable(fail_vec));

endmodule

// File: rtl/liveness_aggregator.sv
module liveness_aggregator
    import liveagg_pkg::*;
#(
    parameter int N_TASKS = 8,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnt_mode,
    input  logic [N_TASKS-1:0]         task_en,
    input  logic [N_TASKS-1:0]         checkin,
    input  logic [N_TASKS-1:0]         entry_inc,
    input  logic [N_TASKS*CNT_W-1:0]   band_lo,
    input  logic [N_TASKS*CNT_W-1:0]   band_hi,
    input  logic                       check_tick,
    output logic                       kick,
    output logic [N_TASKS-1:0]         fail_vec
);

    logic [N_TASKS-1:0] slot_pass;
    logic [N_TASKS-1:0] slot_fail;
    logic               all_pass;

    for (genvar gi = 0; gi < N_TASKS; gi++) begin : g_slot
        liveagg_slot #(.CNT_W(CNT_W)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .checkin    (checkin[gi]),
            .entry_inc  (entry_inc[gi]),
            .check_tick (check_tick),
            .cnt_mode   (cnt_mode),
            .band_lo    (band_lo[gi*CNT_W +: CNT_W]),
            .band_hi    (band_hi[gi*CNT_W +: CNT_W]),
            .pass       (slot_pass[gi])
        );
    end

    assign slot_fail = task_en & ~slot_pass;
    assign all_pass  = (slot_fail == '0);

    liveagg_fsm #(.N_TASKS(N_TASKS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_tick (check_tick),
        .all_pass   (all_pass),
        .slot_fail  (slot_fail),
        .kick       (kick),
        .fail_vec   (fail_vec)
    );

    // R6: a disabled slot never shows up in the status
    a_r6_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
        check_tick |=> ((fail_vec & ~$past(task_en)) == '0));

endmodule

// File: tb/test_liveness_aggregator.sv
module test_liveness_aggregator;

    localparam int N = 8;
    localparam int W = 4;
    localparam int CMAX = (1 << W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_mode = 1'b0;
    logic [N-1:0]     task_en = '1;
    logic [N-1:0]     checkin = '0;
    logic [N-1:0]     entry_inc = '0;
    logic [N*W-1:0]   band_lo = '0;
    logic [N*W-1:0]   band_hi = '0;
    logic             check_tick = 1'b0;
    logic             kick;
    logic [N-1:0]     fail_vec;

    always #2.5 clk = ~clk;

    liveness_aggregator #(.N_TASKS(N), .CNT_W(W)) i_liveness_aggregator (
        .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .task_en(task_en),
        .checkin(checkin), .entry_inc(entry_inc), .band_lo(band_lo),
        .band_hi(band_hi), .check_tick(check_tick), .kick(kick), .fail_vec(fail_vec)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [N:0] exp_q[$];
    string      tag_q[$];
    logic [N-1:0] m_flag = '0;
    int           m_cnt[N];
    logic [N-1:0] last_fail = '0;
    logic         mon_on = 1'b0;
    logic         done = 1'b0;

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {kick,fail_vec} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_band(input int i, input int lo, input int hi);
        band_lo[i*W +: W] = W'(lo);
        band_hi[i*W +: W] = W'(hi);
    endtask

    // one plain cycle of strobes
    task automatic cyc(input logic [N-1:0] ci, input logic [N-1:0] inc);
        @(negedge clk);
        checkin = ci; entry_inc = inc; check_tick = 1'b0;
        m_flag |= ci;
        for (int i = 0; i < N; i++) if (inc[i] && m_cnt[i] < CMAX) m_cnt[i]++;
    endtask

    // tick cycle: predict the verdict from the model, then reload it
    task automatic tick(input string tag, input logic [N-1:0] ci, input logic [N-1:0] inc);
        logic [N-1:0] pf;
        @(negedge clk);
        checkin = ci; entry_inc = inc; check_tick = 1'b1;
        pf = '0;
        for (int i = 0; i < N; i++) begin
            logic ok;
            if (cnt_mode) ok = (m_cnt[i] >= int'(band_lo[i*W +: W])) &&
                               (m_cnt[i] <= int'(band_hi[i*W +: W]));
            else          ok = m_flag[i];
            pf[i] = task_en[i] & ~ok;
        end
        exp_q.push_back({(pf == '0), pf});
        tag_q.push_back(tag);
        m_flag = ci;
        for (int i = 0; i < N; i++) m_cnt[i] = inc[i] ? 1 : 0;
        @(negedge clk);
        check_tick = 1'b0; checkin = '0; entry_inc = '0;
    endtask

    // monitor: just after each edge compare result of a tick, else expect quiet
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (check_tick) begin
                    if (exp_q.size() == 0) begin
                        n_cmp++; n_bad++;
                        $display("FAIL R2: tick without expectation actual=%b expected=none", {kick, fail_vec});
                    end else begin
                        check(tag_q.pop_front(), {kick, fail_vec}, exp_q.pop_front());
                        last_fail = fail_vec;
                    end
                end else begin
                    check("R9/R10 quiet cycle", {kick, fail_vec}, {1'b0, last_fail});
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {kick, fail_vec}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {kick, fail_vec}, '0);
        mon_on = 1'b1;

        // R2: all together, then staggered
        cyc('1, '0);
        cyc('0, '0);
        tick("R2 all at once", '0, '0);
        for (int i = 0; i < N; i++) cyc(N'(1) << i, '0);
        tick("R2 staggered", '0, '0);
        // R3: slot 5 silent
        cyc(8'b1101_1111, '0);
        tick("R3 slot5 missing", '0, '0);
        cyc('1, '0);
        tick("R3 recover", '0, '0);
        // R4: empty interval after pass
        cyc('0, '0);
        tick("R4 cleared after pass", '0, '0);
        // R5: strobes only on the tick go to next interval
        tick("R5 tick-cycle strobes excluded", '1, '0);
        cyc('0, '0);
        tick("R5 carried into next", '0, '0);
        // R6: mask
        task_en = 8'h0F;
        cyc(8'h0F, '0);
        tick("R6 masked upper slots", '0, '0);
        cyc(8'h03, '0);
        tick("R6 masked partial fail", '0, '0);
        task_en = '0;
        tick("R6 all disabled", '0, '0);
        task_en = '1;
        // R11: flag mode ignores inc and bands
        for (int i = 0; i < N; i++) set_band(i, 2, 4);
        cyc('1, '1);
        tick("R11 flag mode ignores counts", '0, '0);
        // R7: counter mode band edges, checkin present but irrelevant
        cnt_mode = 1'b1;
        cyc('1, 8'b1111_1100);
        cyc('1, 8'b1111_1110);
        cyc('1, 8'b1111_1000);
        cyc('1, 8'b1111_0000);
        cyc('1, 8'b1000_0000);
        tick("R7 counts 0..5 versus band 2..4", '0, '0);
        task_en = 8'b0111_1100;
        cyc('0, '1);
        cyc('0, '1);
        cyc('0, '1);
        tick("R7 all inside band", '0, '0);
        // R11: counter mode ignores checkin
        task_en = '1;
        for (int i = 0; i < N; i++) set_band(i, 1, 3);
        cyc('1, '0);
        tick("R11 counter mode ignores checkin", '0, '0);
        // R8: saturation on slot 0
        task_en = 8'h01;
        set_band(0, CMAX, CMAX);
        for (int k = 0; k < 20; k++) cyc('0, 8'h01);
        tick("R8 saturated count", '0, '0);
        // R9: hold status over idle cycles after a failure
        tick("R9 empty interval fails", '0, '0);
        for (int k = 0; k < 10; k++) cyc('0, '0);
        cnt_mode = 1'b0;
        task_en = '1;
        tick("R9 then R3 all missing", '0, '0);
        repeat (3) cyc('0, '0);

        mon_on = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule